// File: doc/BRIEF.md
# Serial Port Bit-Rate Generator

This block produces the timing pulses a serial port needs: a sampling pulse at the rate of the programmable divider and a bit pulse that marks each data bit. It runs in asynchronous, synchronous and smart-card modes. The divider input is chosen from the system clock, the system clock after a fixed prescaler, or rising edges of an external serial clock pin. That pin is synchronised into the system clock domain first, so it must toggle at least 4.5 times slower than the system clock.

Both outputs are one-cycle enables in the system clock domain, not derived clocks. In asynchronous mode a 3-bit fraction stretches some divider periods by one source period. This gives a non-integer average divisor. New divisor and fraction values load only when the counter reloads, so a change never cuts a period short.

In synchronous and smart-card modes the block drives a serial clock output. In synchronous mode it can instead take the external clock and pass it through undivided.

Top module: `baud_gen`

## Requirements
- R1: While reset is asserted, and just after it is released with a zero divisor, `baud_en`, `samp_en` and `sck_out` are all 0.
- R2: `clk_sel` picks the divider source: 0 is the system clock and 1 is the system clock divided by PRESC (default 8). In asynchronous mode with zero fraction, `samp_en` pulses once every `divisor` source periods.
- R3: A divisor of 0 stops all `samp_en` and `baud_en` pulses, except in synchronous mode with the external source.
- R4: `clk_sel` = 2 is reserved and produces no `samp_en` or `baud_en` pulses.
- R5: In asynchronous mode (`mode` 0 or 3), `baud_en` pulses on every 16th `samp_en` pulse when `over8` = 0, and on every 8th when `over8` = 1.
- R6: In asynchronous mode, each `samp_en` period is `divisor` or `divisor`+1 source periods. Any 8 consecutive periods hold exactly `frac` stretched ones, spread evenly.
- R7: In synchronous mode (`mode` 1) with source 0 or 1, `baud_en` and `samp_en` both pulse every `divisor` source periods, and `frac` has no effect.
- R8: In synchronous mode with `clk_sel` = 3, each rising edge of `sck_in` gives exactly one `baud_en` and one `samp_en` pulse, whatever the divisor (even 0). `sck_out` follows `sck_in` after the two-flop synchroniser.
- R9: In synchronous or smart-card mode with `clk_sel` = 0, `sck_out` is high for exactly half of each divider period. This holds for odd divisors too, using half-cycle resolution.
- R10: With `clk_sel` = 1, `sck_out` is high for ceil(`divisor`/2) source periods in each divider period. This is 50:50 only for an even divisor.
- R11: In smart-card mode (`mode` 2), `samp_en` is the card clock at the divider rate. `baud_en` pulses on every `sc_div`-th card clock, and never when `sc_div` = 0. `sck_out` carries the card clock.
- R12: A divisor written during a period takes effect at the next reload. The running period completes with the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | External serial clock pin |
| mode | input | 2 | 0/3 asynchronous, 1 synchronous, 2 smart-card |
| clk_sel | input | 2 | 0 system clock, 1 prescaled, 2 reserved, 3 external pin |
| divisor | input | 16 | Integer divisor, 0 disables |
| frac | input | 3 | Fractional stretch count per 8 periods |
| over8 | input | 1 | Oversampling select: 0 = x16, 1 = x8 |
| sc_div | input | 11 | Smart-card card-clocks per bit |
| baud_en | output | 1 | Bit pulse, one system clock wide |
| samp_en | output | 1 | Sampling or card-clock pulse, one system clock wide |
| sck_out | output | 1 | Serial clock output |

## Verification
The divider is tried with the direct and the prescaled sources, and with even and odd divisors, so pulse spacing reveals whether the prescaler is applied. Eight-period windows with fractions 0, 3 and 5 show whether the stretches are counted and bounded. The same fraction applied in synchronous mode must leave every period even. Duty is measured at half-cycle resolution with divisors 4 and 5, so a missing half-cycle correction on odd values shows up. External edges with a zero divisor show whether the divisor is really bypassed. A divisor written mid-period shows whether it is taken early or at the reload.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int DW    = 16,
  parameter int FW    = 3,
  parameter int SCW   = 11,
  parameter int PRESC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck_in,
  input  logic [1:0]     mode,
  input  logic [1:0]     clk_sel,
  input  logic [DW-1:0]  divisor,
  input  logic [FW-1:0]  frac,
  input  logic           over8,
  input  logic [SCW-1:0] sc_div,
  output logic           baud_en,
  output logic           samp_en,
  output logic           sck_out
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [2:0]     sck_sy;
  logic [PW-1:0]  pc;
  logic [DW-1:0]  cnt, div_q;
  logic [FW-1:0]  acc;
  logic [FW:0]    sum;
  logic [SCW-1:0] bc, lim;
  logic           sck_n;
  logic           rise, pre_tick, src_en, is_sync, is_sc, is_async, sync_ext;
  logic           stretch, tick, btick, sck_p, sck_div, odd_fix;

  assign rise     = sck_sy[1] & ~sck_sy[2];
  assign pre_tick = (pc == PW'(PRESC - 1));
  assign is_sync  = (mode == 2'd1);
  assign is_sc    = (mode == 2'd2);
  assign is_async = ~is_sync & ~is_sc;
  assign sync_ext = is_sync & (clk_sel == 2'd3);

  always_comb begin
    case (clk_sel)
      2'd0:    src_en = 1'b1;
      2'd1:    src_en = pre_tick;
      2'd3:    src_en = rise;
      default: src_en = 1'b0;
    endcase
  end

  assign sum     = {1'b0, acc} + {1'b0, frac};
  assign stretch = is_async & sum[FW];
  assign tick    = src_en & (cnt == '0) & (divisor != '0) & ~sync_ext;
  assign lim     = is_sc ? sc_div : (over8 ? SCW'(8) : SCW'(16));
  assign btick   = tick & (lim != '0) & (bc >= lim - SCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      pc     <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      pc     <= pre_tick ? '0 : pc + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
      acc   <= '0;
    end else if (tick) begin
      cnt   <= divisor - DW'(1) + DW'(stretch);
      div_q <= divisor;
      if (is_async) acc <= sum[FW-1:0];
    end else if (src_en && cnt != '0) begin
      cnt <= cnt - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc <= '0;
    else if (tick && lim != '0) bc <= btick ? '0 : bc + SCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_en <= 1'b0;
      baud_en <= 1'b0;
    end else begin
      samp_en <= sync_ext ? rise : tick;
      baud_en <= sync_ext ? rise : (is_sync ? tick : btick);
    end
  end

  assign sck_p = (cnt >= (div_q >> 1));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sck_n <= 1'b0;
    else        sck_n <= sck_p;
  end

  assign odd_fix = (clk_sel == 2'd0) & div_q[0];
  assign sck_div = odd_fix ? (sck_p & sck_n) : sck_p;
  assign sck_out = sync_ext ? sck_sy[1] :
                   ((is_sync | is_sc) & (div_q != '0) & (clk_sel != 2'd2)) ? sck_div : 1'b0;

  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && clk_sel == 2'd1 && $past(clk_sel) == 2'd1) |=> !samp_en); // R2
  AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0 && !sync_ext) |=> !samp_en); // R3
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2) |=> (!samp_en && !baud_en)); // R4
  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> samp_en); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_q); // R6
  AST_SC_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && sc_div == '0) |=> !baud_en); // R11
endmodule

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_in = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  clk_sel = 2'd0;
  logic [15:0] divisor = 16'd0;
  logic [2:0]  frac = 3'd0;
  logic        over8 = 1'b0;
  logic [10:0] sc_div = 11'd0;
  logic        baud_en, samp_en, sck_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int g [0:15];

  baud_gen i_baud_gen (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .mode(mode), .clk_sel(clk_sel),
    .divisor(divisor), .frac(frac), .over8(over8), .sc_div(sc_div),
    .baud_en(baud_en), .samp_en(samp_en), .sck_out(sck_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int md, input int sel, input int d, input int f,
                     input bit o8, input int scd);
    mode = 2'(md); clk_sel = 2'(sel); divisor = 16'(d);
    frac = 3'(f); over8 = o8; sc_div = 11'(scd);
    repeat (60) @(negedge clk);
  endtask

  function automatic bit pulse(input bit which);
    return which ? baud_en : samp_en;
  endfunction

  task automatic gaps(input bit which, input int n);
    int c;
    c = 0;
    do begin @(negedge clk); c++; end while (!pulse(which) && c < 5000);
    for (int i = 0; i < n; i++) begin
      c = 0;
      do begin @(negedge clk); c++; end while (!pulse(which) && c < 5000);
      g[i] = c;
    end
  endtask

  task automatic count_pulses(input bit which, input int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pulse(which)) n++;
    end
  endtask

  task automatic duty(input int halves, output int hi);
    hi = 0;
    repeat (halves) begin
      @(clk); #1;
      if (sck_out) hi++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 samp in reset", samp_en, 0);
    chk("R1 baud in reset", baud_en, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 samp after reset", samp_en, 0);
    chk("R1 baud after reset", baud_en, 0);
    chk("R1 sck after reset", sck_out, 0);
  endtask

  task automatic t_sources;
    cfg(0, 0, 6, 0, 0, 0);
    gaps(0, 2);
    chk("R2 sysclk gap", g[1], 6);
    cfg(0, 1, 3, 0, 0, 0);
    gaps(0, 2);
    chk("R2 prescaled gap", g[1], 24);
  endtask

  task automatic t_zero;
    int n;
    cfg(0, 0, 0, 0, 0, 0);
    count_pulses(0, 100, n);
    chk("R3 zero divisor samp", n, 0);
    count_pulses(1, 100, n);
    chk("R3 zero divisor baud", n, 0);
  endtask

  task automatic t_reserved;
    int n;
    cfg(0, 2, 4, 0, 0, 0);
    count_pulses(0, 120, n);
    chk("R4 reserved samp", n, 0);
    cfg(1, 2, 4, 0, 0, 0);
    count_pulses(1, 120, n);
    chk("R4 reserved baud", n, 0);
  endtask

  task automatic t_oversample;
    cfg(0, 0, 2, 0, 0, 0);
    gaps(1, 3);
    chk("R5 x16 bit gap", g[2], 32);
    cfg(0, 0, 2, 0, 1, 0);
    gaps(1, 3);
    chk("R5 x8 bit gap", g[2], 16);
  endtask

  task automatic frac_run(input int d, input int f, input string tag);
    int s, longs;
    cfg(0, 0, d, f, 0, 0);
    gaps(0, 10);
    s = 0; longs = 0;
    for (int i = 2; i < 10; i++) begin
      s += g[i];
      if (g[i] == d + 1) longs++;
      else if (g[i] != d) chk({tag, " period out of range"}, g[i], d);
    end
    chk({tag, " eight-period sum"}, s, 8 * d + f);
    chk({tag, " stretched count"}, longs, f);
  endtask

  task automatic t_frac;
    frac_run(4, 3, "R6 f3");
    frac_run(7, 5, "R6 f5");
    frac_run(5, 0, "R6 f0");
  endtask

  task automatic t_sync;
    int s;
    cfg(1, 0, 4, 3, 0, 0);
    gaps(0, 9);
    s = 0;
    for (int i = 1; i < 9; i++) s += g[i];
    chk("R7 sync samp ignores frac", s, 32);
    gaps(1, 2);
    chk("R7 sync baud gap", g[1], 4);
  endtask

  task automatic t_ext;
    int nb, ns;
    cfg(1, 3, 0, 0, 0, 0);
    fork
      begin
        repeat (8) begin
          sck_in = 1'b1; repeat (5) @(negedge clk);
          sck_in = 1'b0; repeat (5) @(negedge clk);
        end
      end
      begin
        nb = 0; ns = 0;
        repeat (95) begin
          @(negedge clk);
          if (baud_en) nb++;
          if (samp_en) ns++;
        end
      end
    join
    chk("R8 ext baud per edge", nb, 8);
    chk("R8 ext samp per edge", ns, 8);
    sck_in = 1'b1; repeat (4) @(negedge clk);
    chk("R8 sck follows high", sck_out, 1);
    sck_in = 1'b0; repeat (4) @(negedge clk);
    chk("R8 sck follows low", sck_out, 0);
  endtask

  task automatic t_duty;
    int hi;
    cfg(1, 0, 5, 0, 0, 0);
    duty(40, hi);
    chk("R9 odd divisor half-cycle duty", hi, 20);
    cfg(1, 0, 4, 0, 0, 0);
    duty(40, hi);
    chk("R9 even divisor duty", hi, 20);
    cfg(1, 1, 4, 0, 0, 0);
    duty(128, hi);
    chk("R10 prescaled even duty", hi, 64);
    cfg(1, 1, 3, 0, 0, 0);
    duty(96, hi);
    chk("R10 prescaled odd duty", hi, 64);
  endtask

  task automatic t_sc;
    int hi, n;
    cfg(2, 0, 3, 0, 0, 5);
    gaps(1, 2);
    chk("R11 card bit gap", g[1], 15);
    gaps(0, 2);
    chk("R11 card clock gap", g[1], 3);
    duty(24, hi);
    chk("R11 card clock on sck", hi, 12);
    cfg(2, 0, 3, 0, 0, 0);
    count_pulses(1, 100, n);
    chk("R11 zero bit divider", n, 0);
  endtask

  task automatic t_change;
    int c;
    cfg(0, 0, 20, 0, 0, 0);
    do @(negedge clk); while (!samp_en);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 3) divisor = 16'd5;
    end while (!samp_en && c < 1000);
    chk("R12 running period keeps old divisor", c, 20);
    gaps(0, 1);
    chk("R12 new divisor after reload", g[0], 5);
  endtask

  initial begin
    t_reset();
    t_sources();
    t_zero();
    t_reserved();
    t_oversample();
    t_frac();
    t_sync();
    t_ext();
    t_duty();
    t_sc();
    t_change();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule